// File: doc/BRIEF.md
# Repeater Port Status Serial Scanner

This block is the status interface of a low-end, unmanaged multiport repeater. It has one AUI port and a parameterised number of twisted-pair ports, eight by default. Two straps set its operating mode while reset is held. The first strap selects minimum mode. The second enables receive polarity correction. The mode then stays fixed until the next reset. In normal management mode the scan output is held low, and the block answers a version-query command byte with a fixed response code.

In minimum mode the block sends one port-status group out of a single serial pin, one bit per strobe cycle. A two-bit select, made from the clock-select and data-select inputs, picks one of four groups. The select is captured at the last system-clock edge on which the strobe is still high. The frame starts with the AUI bit and then runs through the twisted-pair ports in ascending order. Three kinds of status are sticky: bit-rate errors, AUI loopback and AUI SQE-test errors. Each of these flags holds until its bit has been sent, and then clears.

Top module: `rep_status_scan`

## Requirements
- R1: A clock edge with `rst` high loads `min_mode` from `test_strap`. The value loaded at the last such edge is kept after reset ends.
- R2: `pol_corr_en` is loaded at the last reset edge as `si_in AND test_strap`. It is therefore 1 only in minimum mode, and only when `si_in` was 1 during reset.
- R3: Once reset has ended, `min_mode` and `pol_corr_en` ignore `test_strap` and `si_in`. Only another reset changes them.
- R4: The select code `{sclk_in,si_in}` picks the group. 2'b00 gives twisted-pair polarity plus AUI SQE-error. 2'b01 gives bit-rate error for all ports. 2'b10 gives twisted-pair link plus AUI loopback. 2'b11 gives partition for all ports.
- R5: A frame has NUM_TP+1 bits. Frame bit 0 is the AUI port and frame bit k is twisted-pair port k-1. After the last twisted-pair bit the frame wraps to the AUI bit.
- R6: The strobe cycle ends when `strobe` falls. The select is the value present at the last clock edge on which `strobe` was high. `so` takes the next frame bit at the first clock edge on which `strobe` is seen low, and at no other time. A change to the select after the strobe falls has no effect on that bit.
- R7: The sticky flags are the bit-rate errors (`bre_evt` bit 0 is AUI, bit k is twisted-pair k-1), AUI loopback and AUI SQE-error. A one-cycle event pulse sets a flag. The flag reads 1 in every frame until its bit has been sent once, and then clears.
- R8: An event that arrives on the same edge as the scan-out of its flag keeps the flag set. The flag then reads 1 again in the next frame.
- R9: The first strobe after reset starts a frame at the AUI bit. A captured select that differs from the previous one also restarts the frame at the AUI bit.
- R10: `so` is 0 while reset is held and at all times in normal management mode.
- R11: In normal mode, `cmd_valid` with `cmd_byte` = 8'hFF causes `rsp_valid` high for one cycle, one clock later, with `rsp_byte` = 8'h01. Other command bytes get no response, and neither does any command in minimum mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| test_strap | input | 1 | Minimum-mode strap |
| si_in | input | 1 | Polarity strap during reset; select low bit afterwards |
| sclk_in | input | 1 | Select high bit |
| strobe | input | 1 | Strobe; a falling edge ends a strobe cycle |
| bre_evt | input | NUM_TP+1 | Bit-rate-error event pulses, bit 0 AUI |
| aui_sqe_evt | input | 1 | AUI SQE-test-error event pulse |
| aui_lpbk_evt | input | 1 | AUI loopback event pulse |
| tp_pol | input | NUM_TP | Twisted-pair reversed-polarity status |
| tp_link | input | NUM_TP | Twisted-pair link status |
| tp_part | input | NUM_TP | Twisted-pair partition status |
| aui_part | input | 1 | AUI partition status |
| cmd_valid | input | 1 | Management command strobe |
| cmd_byte | input | 8 | Management command byte |
| so | output | 1 | Serial status output |
| min_mode | output | 1 | Minimum mode active |
| pol_corr_en | output | 1 | Receive polarity correction enabled |
| rsp_valid | output | 1 | Version response valid |
| rsp_byte | output | 8 | Version response byte |

## Verification
The straps settle at the last reset edge, so the bench reads `min_mode` and `pol_corr_en` on the falling clock edge right after reset is released. Each strobe holds the select for two high clock cycles and then drops. The bench flips the select at that same falling clock edge and samples `so` one edge later, which is the only edge at which the bit may change (R6). The version response is checked one edge after the command and again one edge later, to confirm it lasts a single cycle. The bench keeps its own frame index and sticky-flag model. It applies event pulses on the same edge as each scan, so every set-versus-clear collision is covered (R8).

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    GRP_POL  = 2'b00,
    GRP_BRE  = 2'b01,
    GRP_LINK = 2'b10,
    GRP_PART = 2'b11
  } grp_e;
endpackage

// File: rtl/rss_strap.sv
module rss_strap (
  input  logic clk,
  input  logic rst,
  input  logic test_strap,
  input  logic si_in,
  output logic min_mode,
  output logic pol_en
);
  // Straps follow their pins while reset is held; the last reset edge wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      min_mode <= test_strap;
      pol_en   <= test_strap & si_in;
    end
  end
endmodule

// File: rtl/rss_sticky.sv
module rss_sticky #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) flag[i] <= 1'b0;
      else     flag[i] <= (flag[i] & ~clr[i]) | set[i];  // set beats clear
    end
  end
endmodule

// File: rtl/rss_scan_seq.sv
module rss_scan_seq
  import rss_pkg::*;
#(
  parameter int N  = 9,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          strobe,
  input  logic [1:0]    sel_in,
  output logic          step,
  output grp_e          sel,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic          strobe_q;
  logic [1:0]    cap_q;
  logic          started_q;
  logic [1:0]    sel_q;
  logic [IW-1:0] idx_q;

  assign step = run && strobe_q && !strobe;
  assign sel  = grp_e'(cap_q);
  always_comb begin
    if (!started_q || cap_q != sel_q) idx = '0;
    else if (idx_q == LAST)           idx = '0;
    else                              idx = idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      cap_q     <= 2'b00;
      started_q <= 1'b0;
      sel_q     <= 2'b00;
      idx_q     <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) cap_q <= sel_in;
      if (step) begin
        started_q <= 1'b1;
        sel_q     <= cap_q;
        idx_q     <= idx;
      end
    end
  end
endmodule

// File: rtl/rep_status_scan.sv
module rep_status_scan
  import rss_pkg::*;
#(
  parameter int          NUM_TP   = 8,
  parameter logic [7:0]  VER_CMD  = 8'hFF,
  parameter logic [3:0]  VER_CODE = 4'b0001,
  localparam int         N        = NUM_TP + 1,
  localparam int         IW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_strap,
  input  logic          si_in,
  input  logic          sclk_in,
  input  logic          strobe,
  input  logic [N-1:0]  bre_evt,
  input  logic          aui_sqe_evt,
  input  logic          aui_lpbk_evt,
  input  logic [NUM_TP-1:0] tp_pol,
  input  logic [NUM_TP-1:0] tp_link,
  input  logic [NUM_TP-1:0] tp_part,
  input  logic          aui_part,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  output logic          so,
  output logic          min_mode,
  output logic          pol_corr_en,
  output logic          rsp_valid,
  output logic [7:0]    rsp_byte
);
  logic          step;
  grp_e          sel;
  logic [IW-1:0] idx;
  logic [N-1:0]  bre_flag, bre_clr;
  logic [1:0]    aui_flag, aui_clr;   // [0] SQE error, [1] loopback
  logic [N-1:0]  grp_vec [4];

  rss_strap u_strap (
    .clk(clk), .rst(rst), .test_strap(test_strap), .si_in(si_in),
    .min_mode(min_mode), .pol_en(pol_corr_en)
  );

  rss_scan_seq #(.N(N)) u_seq (
    .clk(clk), .rst(rst), .run(min_mode), .strobe(strobe),
    .sel_in({sclk_in, si_in}), .step(step), .sel(sel), .idx(idx)
  );

  rss_sticky #(.W(N)) u_bre (
    .clk(clk), .rst(rst), .set(bre_evt), .clr(bre_clr), .flag(bre_flag)
  );

  rss_sticky #(.W(2)) u_aui (
    .clk(clk), .rst(rst), .set({aui_lpbk_evt, aui_sqe_evt}),
    .clr(aui_clr), .flag(aui_flag)
  );

  // Frame bit 0 is the AUI port, bit k is twisted-pair port k-1.
  assign grp_vec[GRP_POL]  = {tp_pol,  aui_flag[0]};
  assign grp_vec[GRP_BRE]  = bre_flag;
  assign grp_vec[GRP_LINK] = {tp_link, aui_flag[1]};
  assign grp_vec[GRP_PART] = {tp_part, aui_part};

  always_comb begin
    bre_clr    = '0;
    aui_clr    = 2'b00;
    if (step) begin
      if (sel == GRP_BRE)                 bre_clr[idx] = 1'b1;
      if (sel == GRP_POL  && idx == '0)   aui_clr[0]   = 1'b1;
      if (sel == GRP_LINK && idx == '0)   aui_clr[1]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !min_mode) so <= 1'b0;
    else if (step)        so <= grp_vec[sel][idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_byte  <= 8'h00;
    end else begin
      rsp_valid <= cmd_valid && !min_mode && cmd_byte == VER_CMD;
      if (cmd_valid && !min_mode && cmd_byte == VER_CMD)
        rsp_byte <= {4'h0, VER_CODE};
    end
  end
endmodule

// File: rtl/rss_checker.sv
module rss_checker (
  input logic       clk,
  input logic       rst,
  input logic       strobe,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       so,
  input logic       min_mode,
  input logic       pol_corr_en,
  input logic       rsp_valid
);
  // R3: the mode does not change outside reset
  a_r3_mode_held_on: assert property (@(posedge clk) disable iff (rst)
    min_mode |=> min_mode);
  a_r3_mode_held_off: assert property (@(posedge clk) disable iff (rst)
    !min_mode |=> !min_mode);
  // R2: polarity correction only in minimum mode
  a_r2_pol_needs_min: assert property (@(posedge clk) disable iff (rst)
    pol_corr_en |-> min_mode);
  // R10: scan output quiet in reset and normal mode
  a_r10_so_reset: assert property (@(posedge clk)
    rst |=> !so);
  a_r10_so_normal: assert property (@(posedge clk) disable iff (rst)
    !min_mode |-> !so);
  // R6: so only moves right after a strobe fall
  a_r6_so_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(so) |-> (!$past(strobe) && $past(strobe, 2)));
  // R11: a response only follows a version query in normal mode
  a_r11_rsp_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(cmd_valid) && $past(cmd_byte) == 8'hFF && !min_mode));
endmodule

bind rep_status_scan rss_checker u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .so(so), .min_mode(min_mode),
  .pol_corr_en(pol_corr_en), .rsp_valid(rsp_valid)
);

// File: tb/rep_status_scan_tb.sv
module rep_status_scan_tb;
  localparam int PERIOD = 10;
  localparam int NTP = 8;
  localparam int N = NTP + 1;

  logic clk = 1'b0;
  logic rst = 1'b1, test_strap = 1'b0, si_in = 1'b0, sclk_in = 1'b0, strobe = 1'b0;
  logic [N-1:0] bre_evt = '0;
  logic aui_sqe_evt = 1'b0, aui_lpbk_evt = 1'b0, aui_part = 1'b0;
  logic [NTP-1:0] tp_pol = '0, tp_link = '0, tp_part = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic so, min_mode, pol_corr_en, rsp_valid;
  logic [7:0] rsp_byte;

  int n_vec = 0, n_bad = 0;
  // bench model
  logic [N-1:0] m_bre;
  logic m_sqe, m_lp, m_started;
  logic [1:0] m_sel;
  int m_idx;

  always #(PERIOD/2) clk = ~clk;

  rep_status_scan #(.NUM_TP(NTP)) u_dut (
    .clk(clk), .rst(rst), .test_strap(test_strap), .si_in(si_in),
    .sclk_in(sclk_in), .strobe(strobe), .bre_evt(bre_evt),
    .aui_sqe_evt(aui_sqe_evt), .aui_lpbk_evt(aui_lpbk_evt),
    .tp_pol(tp_pol), .tp_link(tp_link), .tp_part(tp_part),
    .aui_part(aui_part), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .so(so), .min_mode(min_mode), .pol_corr_en(pol_corr_en),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic t, input logic s);
    rst = 1'b1; test_strap = t; si_in = s;
    repeat (4) @(negedge clk);
    check("R10 so in reset", {7'b0, so}, 8'h00);
    rst = 1'b0; test_strap = ~t; si_in = ~s;
    @(negedge clk);
    check("R1 mode strap", {7'b0, min_mode}, {7'b0, t});
    check("R2 pol strap", {7'b0, pol_corr_en}, {7'b0, t & s});
    m_bre = '0; m_sqe = 1'b0; m_lp = 1'b0; m_started = 1'b0; m_sel = 2'b00; m_idx = 0;
  endtask

  task automatic version(input logic [7:0] cmd, input logic expect_rsp);
    cmd_valid = 1'b1; cmd_byte = cmd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 rsp valid", {7'b0, rsp_valid}, {7'b0, expect_rsp});
    if (expect_rsp) check("R11 rsp byte", rsp_byte, 8'h01);
    @(negedge clk);
    check("R11 rsp one cycle", {7'b0, rsp_valid}, 8'h00);
  endtask

  // One strobe cycle; events land on the same edge as the scan (R8).
  task automatic strobe_cycle(input logic [1:0] sel, input logic [N-1:0] bev,
                              input logic sev, input logic lev, input logic mm);
    logic exp;
    sclk_in = sel[1]; si_in = sel[0]; strobe = 1'b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0; sclk_in = ~sel[1]; si_in = ~sel[0];   // late change ignored (R6)
    bre_evt = bev; aui_sqe_evt = sev; aui_lpbk_evt = lev;
    if (mm) begin
      // R9 restart, R5 ordering and wrap
      if (!m_started || sel != m_sel) m_idx = 0;
      else m_idx = (m_idx + 1) % N;
      m_started = 1'b1; m_sel = sel;
      case (sel)  // R4 group mapping
        2'b00: exp = (m_idx == 0) ? m_sqe : tp_pol[m_idx-1];
        2'b01: exp = m_bre[m_idx];
        2'b10: exp = (m_idx == 0) ? m_lp : tp_link[m_idx-1];
        default: exp = (m_idx == 0) ? aui_part : tp_part[m_idx-1];
      endcase
      // R7 clear after scan-out, R8 new event wins
      if (sel == 2'b01) m_bre[m_idx] = 1'b0;
      if (sel == 2'b00 && m_idx == 0) m_sqe = 1'b0;
      if (sel == 2'b10 && m_idx == 0) m_lp = 1'b0;
    end else exp = 1'b0;
    m_bre = m_bre | bev; m_sqe = m_sqe | sev; m_lp = m_lp | lev;
    @(negedge clk);
    bre_evt = '0; aui_sqe_evt = 1'b0; aui_lpbk_evt = 1'b0;
    check(mm ? "R4 R5 R6 R7 R8 R9 so bit" : "R10 so in normal", {7'b0, so}, {7'b0, exp});
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tp_pol = 8'hA5; tp_link = 8'h3C; tp_part = 8'h96; aui_part = 1'b1;
    // normal management mode
    do_reset(1'b0, 1'b1);
    version(8'hFF, 1'b1);
    version(8'hFE, 1'b0);
    version(8'h7F, 1'b0);
    for (int k = 0; k < 4; k++) strobe_cycle(2'(k), 9'h1FF, 1'b1, 1'b1, 1'b0);
    check("R3 mode stays normal", {7'b0, min_mode}, 8'h00);
    // minimum mode, polarity disabled then enabled
    do_reset(1'b1, 1'b0);
    do_reset(1'b1, 1'b1);
    version(8'hFF, 1'b0);
    check("R3 mode stays min", {7'b0, min_mode}, 8'h01);
    check("R3 pol stays", {7'b0, pol_corr_en}, 8'h01);
    // sweep every group across more than two frames
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      bre_evt = 9'h0A5 << g; aui_sqe_evt = 1'b1; aui_lpbk_evt = 1'b1;
      @(negedge clk);
      bre_evt = '0; aui_sqe_evt = 1'b0; aui_lpbk_evt = 1'b0;
      m_bre = m_bre | (9'h0A5 << g); m_sqe = 1'b1; m_lp = 1'b1;
      tp_pol = tp_pol ^ 8'h0F; tp_link = {tp_link[0], tp_link[7:1]};
      for (int k = 0; k < 20; k++)
        strobe_cycle(2'(g), (k % 5 == 2) ? (9'h1 << (k % N)) : '0,
                     k == 9, k == 18, 1'b1);
    end
    // select changes restart the frame
    for (int k = 0; k < 24; k++)
      strobe_cycle(2'((k / 3) % 4), (k % 4 == 0) ? 9'h111 : '0,
                   k % 7 == 0, k % 5 == 0, 1'b1);
    // mode persists until reset, then normal again
    do_reset(1'b0, 1'b0);
    strobe_cycle(2'b11, '0, 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule